// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This controller sits between a simple in-order pipeline and main memory. It uses a direct-mapped cache with one 32-bit word per line. The tag and data storage are SRAM arrays outside the controller. The controller keeps only a valid bit for each line, the address of a pending miss, and a small posted write buffer.

On each access the controller puts the line index on the arrays. It compares the stored tag with the upper address bits and, on a hit, returns the word in the same cycle with no stall. A load miss stalls the pipeline. The controller first lets the write buffer empty, then reads the word from memory, returns it and fills the line.

Stores always write the full word and its tag into the line, whether they hit or miss. They are also queued in a four-entry FIFO that drains to memory in the background. The pipeline therefore stalls on a store only when that FIFO is full.

Top module: `wtCache`

## Requirements
- R1: A 32-bit byte address maps as follows: the compared tag is bits [31:12], always 20 bits wide; the line index is bits [IDX_W+1:2], with IDX_W between 10 and 18; bits [1:0] are ignored. Two addresses that share an index but differ in the tag evict each other.
- R2: Reset clears every valid bit. A lookup hits only when the line's valid bit is set and the stored tag equals the address tag. A line whose array tag happens to match but which was never filled since reset is a miss.
- R3: A load that hits keeps `stall` low and presents the stored word on `rdata` in the same cycle.
- R4: A load that misses raises `stall` in its first cycle. In the cycle the memory read is acknowledged, `stall` drops, `rdata` equals `memRdata`, and the array is written with that word and its tag. A later load of the same address hits.
- R5: While a miss is pending, `stall` stays high and no other access is accepted. No array write occurs except the fill.
- R6: A store accepted with `stall` low writes its full data word and its tag into the array line (`arrWe` high) in the same cycle, and marks the line valid. This applies to store hits and store misses alike.
- R7: Every accepted store is sent to memory as a write (`memWe` high). Writes go out in the order the stores were accepted, with the same word address and data.
- R8: A store stalls exactly when all four write-buffer entries are occupied at that cycle. Otherwise it is accepted without a stall.
- R9: The memory read for a load miss (`memReq` high, `memWe` low) is issued only after every earlier buffered store has been acknowledged. The load therefore returns the most recently stored value.
- R10: Once `memReq` is raised, `memReq`, `memWe`, `memAddr` and `memWdata` stay stable until `memAck` is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Pipeline access present. The pipeline holds it while `stall` is high. |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address of the access |
| reqWdata | input | 32 | Store data |
| rdata | output | 32 | Load result, valid in the cycle the load completes |
| stall | output | 1 | The access is not accepted in this cycle |
| arrIdx | output | IDX_W | Index to the tag and data arrays |
| arrTagRd | input | 20 | Tag read from the array at `arrIdx` (combinational) |
| arrDataRd | input | 32 | Word read from the array at `arrIdx` (combinational) |
| arrWe | output | 1 | Write the array line at `arrIdx` on the next clock edge |
| arrWtag | output | 20 | Tag to write |
| arrWdata | output | 32 | Word to write |
| memReq | output | 1 | Memory request pending |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Request completes at this edge. For a read, the data is present. |
| memRdata | input | 32 | Memory read data, valid with `memAck` |

## Verification
Hit results (`rdata`, `stall` low), store array writes and fill data are all combinational. They are due in the cycle the request or the read acknowledge is present. Valid bits, the buffer count and the miss state change at the following edge, so their effects show in the next cycle.

The bench changes inputs on the falling edge. It decides `memAck` from the already settled `memReq`, then samples every output two time units later, well before the next rising edge. A behavioural model then predicts every output for the next cycle. That model is built from queues and arrays, and the bench updates it with the effect of that edge.

// File: rtl/cachePkg.sv
package cachePkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 20;
  localparam int WORD_W = ADDR_W - 2;

  typedef enum logic {ST_RUN, ST_MISS} ctrlState_t;

  typedef struct packed {
    logic captureMiss;
    logic fillLine;
    logic storeLine;
    logic pushWb;
    logic popWb;
    logic missPhase;
  } ctrlStrobes_t;
endpackage

// File: rtl/cacheCtrl.sv
module cacheCtrl
  import cachePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         lineHit,
  input  logic         wbFull,
  input  logic         wbEmpty,
  input  logic         memAck,
  output logic         stall,
  output ctrlStrobes_t strobes
);
  ctrlState_t stateQ, stateNext;

  always_comb begin
    strobes           = '0;
    stall             = 1'b0;
    stateNext         = stateQ;
    strobes.missPhase = (stateQ == ST_MISS);
    // a buffered write completes whenever an ack arrives with entries queued
    strobes.popWb     = memAck && !wbEmpty;
    unique case (stateQ)
      ST_RUN: begin
        if (reqValid) begin
          if (reqWrite) begin
            if (wbFull) begin
              stall = 1'b1;
            end else begin
              strobes.storeLine = 1'b1;
              strobes.pushWb    = 1'b1;
            end
          end else if (!lineHit) begin
            stall               = 1'b1;
            strobes.captureMiss = 1'b1;
            stateNext           = ST_MISS;
          end
        end
      end
      ST_MISS: begin
        // the read is only outstanding once the buffer is empty
        if (memAck && wbEmpty) begin
          strobes.fillLine = 1'b1;
          stateNext        = ST_RUN;
        end else begin
          stall = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateNext;
  end
endmodule

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cachePkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int WB_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [TAG_W-1:0]    arrTagRd,
  input  logic [DATA_W-1:0]   arrDataRd,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                lineHit,
  output logic                wbFull,
  output logic                wbEmpty,
  output logic [DATA_W-1:0]   rdata,
  output logic [IDX_W-1:0]    arrIdx,
  output logic                arrWe,
  output logic [TAG_W-1:0]    arrWtag,
  output logic [DATA_W-1:0]   arrWdata,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int PTR_W = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;
  localparam int CNT_W = $clog2(WB_DEPTH + 1);

  logic [LINES-1:0]  validQ;
  logic [WORD_W-1:0] missWordQ;
  logic [WORD_W-1:0] lookWord;
  logic [TAG_W-1:0]  lookTag;
  logic [1:0]        unusedByteSel;

  logic [WORD_W-1:0] wbWordQ [WB_DEPTH];
  logic [DATA_W-1:0] wbDataQ [WB_DEPTH];
  logic [PTR_W-1:0]  headQ, tailQ;
  logic [CNT_W-1:0]  countQ;

  assign unusedByteSel = reqAddr[1:0];

  // lookup address: the held miss address while a miss is pending
  assign lookWord = strobes.missPhase ? missWordQ : reqAddr[ADDR_W-1:2];
  assign arrIdx   = lookWord[IDX_W-1:0];
  assign lookTag  = lookWord[WORD_W-1:WORD_W-TAG_W];
  assign lineHit  = validQ[arrIdx] && (arrTagRd == lookTag);

  assign arrWe    = strobes.storeLine || strobes.fillLine;
  assign arrWtag  = lookTag;
  assign arrWdata = strobes.fillLine ? memRdata : reqWdata;
  assign rdata    = strobes.fillLine ? memRdata : arrDataRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      missWordQ <= '0;
    end else begin
      if (arrWe)               validQ[arrIdx] <= 1'b1;
      if (strobes.captureMiss) missWordQ      <= reqAddr[ADDR_W-1:2];
    end
  end

  // posted write buffer, first in first out
  assign wbFull  = (countQ == CNT_W'(WB_DEPTH));
  assign wbEmpty = (countQ == '0);

  always_ff @(posedge clk) begin
    if (strobes.pushWb) begin
      wbWordQ[tailQ] <= reqAddr[ADDR_W-1:2];
      wbDataQ[tailQ] <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      if (strobes.pushWb) tailQ <= (tailQ == PTR_W'(WB_DEPTH - 1)) ? '0 : tailQ + PTR_W'(1);
      if (strobes.popWb)  headQ <= (headQ == PTR_W'(WB_DEPTH - 1)) ? '0 : headQ + PTR_W'(1);
      countQ <= countQ + CNT_W'(strobes.pushWb) - CNT_W'(strobes.popWb);
    end
  end

  // buffered writes take the port first; the miss read follows once empty
  assign memReq   = !wbEmpty || strobes.missPhase;
  assign memWe    = !wbEmpty;
  assign memAddr  = wbEmpty ? {missWordQ, 2'b00} : {wbWordQ[headQ], 2'b00};
  assign memWdata = wbDataQ[headQ];
endmodule

// File: rtl/wtCache.sv
module wtCache
  import cachePkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int WB_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [31:0]         reqAddr,
  input  logic [31:0]         reqWdata,
  output logic [31:0]         rdata,
  output logic                stall,
  output logic [IDX_W-1:0]    arrIdx,
  input  logic [19:0]         arrTagRd,
  input  logic [31:0]         arrDataRd,
  output logic                arrWe,
  output logic [19:0]         arrWtag,
  output logic [31:0]         arrWdata,
  output logic                memReq,
  output logic                memWe,
  output logic [31:0]         memAddr,
  output logic [31:0]         memWdata,
  input  logic                memAck,
  input  logic [31:0]         memRdata
);
  ctrlStrobes_t strobes;
  logic         lineHit;
  logic         wbFull;
  logic         wbEmpty;
  logic         missPhase;

  assign missPhase = strobes.missPhase;

  cacheCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .lineHit  (lineHit),
    .wbFull   (wbFull),
    .wbEmpty  (wbEmpty),
    .memAck   (memAck),
    .stall    (stall),
    .strobes  (strobes)
  );

  cacheDatapath #(.IDX_W(IDX_W), .WB_DEPTH(WB_DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .arrTagRd  (arrTagRd),
    .arrDataRd (arrDataRd),
    .memRdata  (memRdata),
    .lineHit   (lineHit),
    .wbFull    (wbFull),
    .wbEmpty   (wbEmpty),
    .rdata     (rdata),
    .arrIdx    (arrIdx),
    .arrWe     (arrWe),
    .arrWtag   (arrWtag),
    .arrWdata  (arrWdata),
    .memReq    (memReq),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );
endmodule

// File: rtl/cacheChk.sv
module cacheChk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic        stall,
  input logic        missPhase,
  input logic        lineHit,
  input logic        wbFull,
  input logic        arrWe,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata
);
  // R3
  hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!missPhase && reqValid && !reqWrite && lineHit) |-> !stall);

  // R4
  fill_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missPhase && arrWe) |-> !stall);

  // R5
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missPhase && !arrWe) |-> stall);

  // R6
  store_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !stall) |-> arrWe);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbFull |-> !(reqValid && reqWrite && !stall));

  // R8
  full_persist_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbFull && !(memAck && memWe)) |=> wbFull);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));
endmodule

bind wtCache cacheChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .stall     (stall),
  .missPhase (missPhase),
  .lineHit   (lineHit),
  .wbFull    (wbFull),
  .arrWe     (arrWe),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAck    (memAck),
  .memAddr   (memAddr),
  .memWdata  (memWdata)
);

// File: tb/sim_wtCache.sv
module sim_wtCache;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 10;
  localparam int LINES      = 1 << IDX_W;
  localparam int OP_IDLE = 0, OP_LOAD = 1, OP_STORE = 2, OP_LAT = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [31:0] rdata;
  logic stall;
  logic [IDX_W-1:0] arrIdx;
  logic [19:0] arrTagRd;
  logic [31:0] arrDataRd;
  logic arrWe;
  logic [19:0] arrWtag;
  logic [31:0] arrWdata;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  wtCache #(.IDX_W(IDX_W), .WB_DEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdata(rdata), .stall(stall),
    .arrIdx(arrIdx), .arrTagRd(arrTagRd), .arrDataRd(arrDataRd), .arrWe(arrWe),
    .arrWtag(arrWtag), .arrWdata(arrWdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // external SRAM arrays, read asynchronously
  logic [19:0] sramTag  [LINES];
  logic [31:0] sramData [LINES];
  assign arrTagRd  = sramTag[arrIdx];
  assign arrDataRd = sramData[arrIdx];
  always @(posedge clk) if (arrWe) begin
    sramTag[arrIdx]  <= arrWtag;
    sramData[arrIdx] <= arrWdata;
  end

  // memories and reference model
  logic [31:0] mainMem [logic [29:0]];
  logic [31:0] archMem [logic [29:0]];
  bit          mValid [LINES];
  logic [19:0] mTag   [LINES];
  logic [31:0] mData  [LINES];
  logic [29:0] qWord [$];
  logic [31:0] qData [$];
  bit          mInMiss = 0;
  logic [29:0] mMissWord = '0;
  int lat = 3, waitCnt = 0;

  int opKind [$];
  logic [29:0] opWord [$];
  logic [31:0] opData [$];

  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic logic [31:0] dfltWord(logic [29:0] w);
    return {w[15:0], ~w[15:0]};
  endfunction
  function automatic logic [31:0] memRead(logic [29:0] w);
    return mainMem.exists(w) ? mainMem[w] : dfltWord(w);
  endfunction
  function automatic logic [31:0] archRead(logic [29:0] w);
    return archMem.exists(w) ? archMem[w] : dfltWord(w);
  endfunction
  function automatic logic [29:0] mkWord(logic [19:0] tag, logic [9:0] idx);
    return {tag, idx};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%h expected=%h", rq, $time, act, exp);
    end
  endtask

  task automatic addOp(int k, logic [29:0] w, logic [31:0] d);
    opKind.push_back(k); opWord.push_back(w); opData.push_back(d);
  endtask

  task automatic runCycle(ref int opIdx);
    int k; logic [29:0] w; logic [31:0] d;
    bit isWr, full, hit, wasWrite, fillNow, expStall, expWe, expMemReq;
    int idx;
    while (opIdx < opKind.size() && opKind[opIdx] == OP_LAT) begin
      lat = opData[opIdx]; opIdx++;
    end
    @(negedge clk);
    k = (opIdx < opKind.size()) ? opKind[opIdx] : OP_IDLE;
    w = (opIdx < opKind.size()) ? opWord[opIdx] : '0;
    d = (opIdx < opKind.size()) ? opData[opIdx] : '0;
    reqValid = (k == OP_LOAD || k == OP_STORE);
    reqWrite = (k == OP_STORE);
    reqAddr  = {w, 2'b00};
    reqWdata = d;
    #1;
    memAck = memReq && (waitCnt + 1 >= lat);
    memRdata = (memReq && !memWe) ? memRead(memAddr[31:2]) : 32'h0;
    #1;
    // memory side
    expMemReq = (qWord.size() > 0) || mInMiss;
    chk(mInMiss && qWord.size() == 0 ? "R9 read issue" : "R7 write pending", 32'(memReq), 32'(expMemReq));
    if (memReq && expMemReq) begin
      if (qWord.size() > 0) begin
        chk("R9 write before read", 32'(memWe), 32'd1);
        chk("R7 fifo address (R10 held)", memAddr, {qWord[0], 2'b00});
        chk("R7 fifo data", memWdata, qData[0]);
      end else begin
        chk("R9 read kind", 32'(memWe), 32'd0);
        chk("R4 read address (R10 held)", memAddr, {mMissWord, 2'b00});
      end
    end
    // pipeline side
    isWr = reqWrite; full = (qWord.size() == 4); hit = 0;
    wasWrite = memAck && qWord.size() > 0;
    fillNow  = mInMiss && memAck && qWord.size() == 0;
    idx = int'(w[IDX_W-1:0]);
    if (mInMiss) begin
      expStall = !fillNow; expWe = fillNow;
      chk("R5 stall during miss", 32'(stall), 32'(expStall));
      chk("R5 no stray array write", 32'(arrWe), 32'(expWe));
      if (fillNow) begin
        chk("R4 fill data on rdata", rdata, archRead(mMissWord));
        chk("R4 fill tag", 32'(arrWtag), 32'(mMissWord[29:10]));
      end
    end else if (reqValid && isWr) begin
      chk("R8 store stall vs full", 32'(stall), 32'(full));
      chk("R6 store array write", 32'(arrWe), 32'(!full));
      if (!full) begin
        chk("R6 store tag (R1)", 32'(arrWtag), 32'(w[29:10]));
        chk("R6 store data", arrWdata, d);
        chk("R1 index", 32'(arrIdx), 32'(w[IDX_W-1:0]));
      end
    end else if (reqValid) begin
      hit = mValid[idx] && (mTag[idx] == w[29:10]);
      chk(hit ? "R3 hit no stall" : "R2 miss stall (R1)", 32'(stall), 32'(!hit));
      chk("R3 no array write on lookup", 32'(arrWe), 32'd0);
      if (hit) chk("R3 hit data", rdata, archRead(w));
    end else begin
      chk("R3 idle no stall", 32'(stall), 32'd0);
      chk("R6 idle no array write", 32'(arrWe), 32'd0);
    end
    // model update for the coming edge
    if (memAck) waitCnt = 0; else if (memReq) waitCnt++; else waitCnt = 0;
    if (wasWrite) begin
      mainMem[qWord[0]] = qData[0];
      void'(qWord.pop_front()); void'(qData.pop_front());
    end
    if (fillNow) begin
      mValid[int'(mMissWord[IDX_W-1:0])] = 1;
      mTag[int'(mMissWord[IDX_W-1:0])]   = mMissWord[29:10];
      mData[int'(mMissWord[IDX_W-1:0])]  = archRead(mMissWord);
      mInMiss = 0;
      opIdx++;
    end else if (!mInMiss) begin
      if (!reqValid) opIdx++;
      else if (isWr) begin
        if (!full) begin
          qWord.push_back(w); qData.push_back(d);
          archMem[w] = d;
          mValid[idx] = 1; mTag[idx] = w[29:10]; mData[idx] = d;
          opIdx++;
        end
      end else if (hit) opIdx++;
      else begin
        mInMiss = 1; mMissWord = w;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    int opIdx;
    logic [31:0] rnd;
    for (int i = 0; i < LINES; i++) begin
      sramTag[i]  = 20'h0;          // would falsely hit tag 0 without valid bits (R2)
      sramData[i] = 32'hBAD0_0000 | i;
      mValid[i] = 0; mTag[i] = '0; mData[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R2 reset no stall", 32'(stall), 32'd0);
    chk("R7 reset no memory request", 32'(memReq), 32'd0);
    chk("R6 reset no array write", 32'(arrWe), 32'd0);
    rstN = 1'b1;

    addOp(OP_LAT, '0, 3);
    addOp(OP_IDLE, '0, 0); addOp(OP_IDLE, '0, 0);
    addOp(OP_LOAD, mkWord(20'h0, 10'd16), 0);     // R2 invalid line, tag 0
    addOp(OP_LOAD, mkWord(20'h0, 10'd16), 0);     // R4 now hits
    addOp(OP_LOAD, mkWord(20'h1, 10'd16), 0);     // R1 conflict evicts
    addOp(OP_LOAD, mkWord(20'h0, 10'd16), 0);
    addOp(OP_LAT, '0, 4);
    for (int s = 0; s < 6; s++) addOp(OP_STORE, mkWord(20'h5, 10'(20 + s)), 32'hA000_0000 + s); // R8
    addOp(OP_LOAD, mkWord(20'h5, 10'd20), 0);     // R6 store hit visible
    addOp(OP_LOAD, mkWord(20'h7, 10'd30), 0);     // R9 waits for drain
    addOp(OP_STORE, mkWord(20'h9, 10'd16), 32'h1234_5678);
    addOp(OP_LOAD, mkWord(20'h9, 10'd16), 0);
    addOp(OP_STORE, mkWord(20'h3, 10'd40), 32'h5555_AAAA);
    addOp(OP_LOAD, mkWord(20'h4, 10'd40), 0);     // R9 miss right after a store to the same line
    addOp(OP_LAT, '0, 1);
    addOp(OP_LOAD, mkWord(20'h3, 10'd40), 0);     // R9 returns the stored value
    rnd = 32'h1F2E_3D4C;
    for (int n = 0; n < 500; n++) begin
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      if (n % 60 == 0) addOp(OP_LAT, '0, 1 + (rnd[27:26]));
      if (rnd[3:0] < 6)
        addOp(OP_STORE, mkWord(20'(1 + rnd[5:4] % 3), 10'(5 + rnd[7:6])), rnd ^ 32'h0F0F_0F0F);
      else if (rnd[3:0] < 14)
        addOp(OP_LOAD, mkWord(20'(1 + rnd[5:4] % 3), 10'(5 + rnd[7:6])), 0);
      else
        addOp(OP_IDLE, '0, 0);
    end

    opIdx = 0;
    while (opIdx < opKind.size() || qWord.size() > 0 || mInMiss) runCycle(opIdx);
    repeat (2) runCycle(opIdx);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule